// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is one counting channel of a programmable interval timer. A host processor reaches it over an 8-bit bus with active-low chip select, read strobe and write strobe, and a two-bit address. One address reaches the control register and another reaches this channel's 16-bit count. A control byte sets the operating mode and the byte format of later count accesses. It can also freeze the running count for a later read.

The channel counts on a count-enable strobe `tick`, which is one system clock wide. Its behaviour under the `gate` input and the level on `out` depend on the mode. In the periodic rate-generator mode, `out` stays high and drops for one tick interval once every N ticks. In the retriggerable one-shot mode, a rising edge on `gate` starts a low pulse that lasts N ticks. A later rising edge restarts that pulse from the full count. In the rate-generator mode, a low level on `gate` suspends counting.

Several channels share one bus. Each instance takes its address through the `CHAN_ID` parameter. All instances decode writes to address 3, and each channel accepts only the control bytes whose select field equals its own `CHAN_ID`.

Top module: `tmr_channel`

## Requirements
- R1: After reset `out` is high, nothing counts, the access format is low-then-high byte, and the count reads back as 0x0000.
- R2: A bus write happens on the first system clock with `cs_n` and `wr_n` both low. Address 3 is the control register. A control byte is accepted only when bits [7:6] equal `CHAN_ID`, so select code 3 is ignored. Bits [5:4] give the access format: 0 latch, 1 low byte only, 2 high byte only, 3 low then high. Bits [3:1] give the mode: 001 is one-shot, x10 is rate generator. A byte with any other mode code and a nonzero format is ignored, and so is bit 0.
- R3: In format 1 a count write loads {0x00, byte}. In format 2 it loads {byte, 0x00}. In format 3 the first write stores the low byte and the second write completes the count. An accepted mode byte sends the next write back to the low byte.
- R4: An accepted mode byte drives `out` high on the next clock. It stops counting and cancels any pending trigger until a new count is written.
- R5: In the rate-generator mode, the first tick with `gate` high after a count write loads the count N. `out` goes low on the tick that brings the count to 1. The next tick reloads N and drives `out` high, so `out` has a period of N ticks.
- R6: A count written while the rate generator is running takes effect only at the next reload.
- R7: In the rate-generator mode, while `gate` is low, ticks leave both the count and `out` unchanged.
- R8: In the one-shot mode, ticks do nothing until `gate` rises after a count write. The next tick then loads N and drives `out` low. `out` returns high on the tick that brings the count to 0, so the pulse lasts N ticks.
- R9: In the one-shot mode, a rising edge on `gate` during a pulse reloads N on the next tick and extends the pulse. A rising edge after the pulse has ended fires the pulse again without a new count write.
- R10: `dout_oe` is high and `dout` carries data only while `cs_n` and `rd_n` are low and `addr` equals `CHAN_ID`. Otherwise both are zero. Format 1 reads the low byte, format 2 reads the high byte, and format 3 reads the low byte then the high byte.
- R11: A latch command freezes the count at that instant. Reads then return the frozen value while counting goes on. Further latch commands are ignored until the frozen value has been read completely: both bytes in format 3, one byte otherwise. After that, reads return the live count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register address: 3 is the control register, `CHAN_ID` is the count |
| din | input | 8 | Write data from the host |
| dout | output | 8 | Read data to the host, zero when not read |
| dout_oe | output | 1 | High while the channel drives read data |
| tick | input | 1 | Count-enable strobe, one clock wide per count |
| gate | input | 1 | Gate input, synchronous to `clk` |
| out | output | 1 | Timer output |

## Verification
The assertions check the following on every clock:
- `out` rises after every accepted mode byte.
- `out` changes only on a tick or a mode write.
- A rate-generator low phase never outlasts one gated tick.
- A low gate freezes both the count and `out`.
- The read bus stays quiet outside a read.

Only the bench scenarios can show the count-dependent timing:
- where in an N-tick period `out` falls;
- how long a one-shot pulse lasts, and how far a retrigger extends it;
- when a count written mid-run takes effect.

The bench scenarios also cover the latch hold-and-release order, the byte-pointer reset, and the rejection of control bytes for other channels or unknown modes. Each of these is observed through `out` and through the values read back.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int BUS_W = 8;
  localparam int CNT_W = 2 * BUS_W;
  localparam logic [1:0] CW_ADDR = 2'b11;

  typedef enum logic {
    MODE_ONESHOT = 1'b0,
    MODE_RATE    = 1'b1
  } tmr_mode_e;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'b00,
    ACC_LO    = 2'b01,
    ACC_HI    = 2'b10,
    ACC_BOTH  = 2'b11
  } tmr_acc_e;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter logic [1:0] CHAN_ID = 2'b00
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  logic [1:0]       addr,
  input  logic [BUS_W-1:0] din,
  output tmr_mode_e        mode,
  output tmr_acc_e         acc,
  output logic             cw_wr,
  output logic             latch_cmd,
  output logic             load_stb,
  output logic [CNT_W-1:0] load_val
);
  logic             cw_hit, cnt_hit, mode_ok;
  tmr_mode_e        mode_q, mode_n;
  tmr_acc_e         acc_q, acc_n;
  logic             wptr_q, wptr_n;
  logic [BUS_W-1:0] stage_q, stage_n;

  // Control-byte decode: [7:6] select, [5:4] format, [3:1] mode
  assign cw_hit    = wr_stb && (addr == CW_ADDR) && (din[7:6] == CHAN_ID);
  assign mode_ok   = (din[3:1] == 3'b001) || (din[2:1] == 2'b10);
  assign latch_cmd = cw_hit && (din[5:4] == 2'b00);
  assign cw_wr     = cw_hit && (din[5:4] != 2'b00) && mode_ok;
  assign cnt_hit   = wr_stb && (addr == CHAN_ID);
  assign load_stb  = cnt_hit && ((acc_q != ACC_BOTH) || wptr_q);

  always_comb begin
    case (acc_q)
      ACC_LO:  load_val = {{BUS_W{1'b0}}, din};
      ACC_HI:  load_val = {din, {BUS_W{1'b0}}};
      default: load_val = {din, stage_q};
    endcase
  end

  always_comb begin
    mode_n  = mode_q;
    acc_n   = acc_q;
    wptr_n  = wptr_q;
    stage_n = stage_q;
    if (cw_wr) begin
      mode_n = (din[3:1] == 3'b001) ? MODE_ONESHOT : MODE_RATE;
      acc_n  = tmr_acc_e'(din[5:4]);
      wptr_n = 1'b0;
    end else if (cnt_hit && (acc_q == ACC_BOTH)) begin
      if (!wptr_q) stage_n = din;
      wptr_n = ~wptr_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_RATE;
      acc_q   <= ACC_BOTH;
      wptr_q  <= 1'b0;
      stage_q <= '0;
    end else begin
      mode_q  <= mode_n;
      acc_q   <= acc_n;
      wptr_q  <= wptr_n;
      stage_q <= stage_n;
    end
  end

  assign mode = mode_q;
  assign acc  = acc_q;
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  tmr_mode_e        mode,
  input  logic             cw_wr,
  input  logic             load_stb,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  input  logic             gate,
  output logic [CNT_W-1:0] count,
  output logic             out
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

  logic [CNT_W-1:0] cnt_q, cnt_n, rel_q, rel_n;
  logic             out_q, out_n;
  logic             run_q, run_n;    // rate generator counting
  logic             pend_q, pend_n;  // rate generator load waiting
  logic             arm_q, arm_n;    // one-shot has a count
  logic             act_q, act_n;    // one-shot pulse in progress
  logic             trg_q, trg_n;    // one-shot trigger waiting for a tick
  logic             gate_q, gate_rise;

  assign gate_rise = gate && !gate_q;

  always_comb begin
    cnt_n  = cnt_q;
    rel_n  = rel_q;
    out_n  = out_q;
    run_n  = run_q;
    pend_n = pend_q;
    arm_n  = arm_q;
    act_n  = act_q;
    trg_n  = trg_q;
    if (cw_wr) begin
      out_n  = 1'b1;
      run_n  = 1'b0;
      pend_n = 1'b0;
      arm_n  = 1'b0;
      act_n  = 1'b0;
      trg_n  = 1'b0;
    end else begin
      if (load_stb) begin
        rel_n = load_val;
        if (mode == MODE_RATE) begin
          if (!run_q) pend_n = 1'b1;
        end else begin
          arm_n = 1'b1;
        end
      end
      if (tick) begin
        if (mode == MODE_RATE) begin
          if (gate) begin
            if (pend_q) begin
              cnt_n  = rel_q;
              run_n  = 1'b1;
              pend_n = 1'b0;
              out_n  = 1'b1;
            end else if (run_q) begin
              if (cnt_q == TWO) begin
                cnt_n = ONE;
                out_n = 1'b0;
              end else if (cnt_q == ONE) begin
                cnt_n = rel_q;
                out_n = 1'b1;
              end else begin
                cnt_n = cnt_q - ONE;
              end
            end
          end
        end else begin
          if (trg_q) begin
            cnt_n = rel_q;
            act_n = 1'b1;
            out_n = 1'b0;
            trg_n = 1'b0;
          end else if (act_q) begin
            cnt_n = cnt_q - ONE;
            if (cnt_q == ONE) begin
              act_n = 1'b0;
              out_n = 1'b1;
            end
          end
        end
      end
      if ((mode == MODE_ONESHOT) && gate_rise && (arm_q || load_stb))
        trg_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      rel_q  <= '0;
      out_q  <= 1'b1;
      run_q  <= 1'b0;
      pend_q <= 1'b0;
      arm_q  <= 1'b0;
      act_q  <= 1'b0;
      trg_q  <= 1'b0;
      gate_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      rel_q  <= rel_n;
      out_q  <= out_n;
      run_q  <= run_n;
      pend_q <= pend_n;
      arm_q  <= arm_n;
      act_q  <= act_n;
      trg_q  <= trg_n;
      gate_q <= gate;
    end
  end

  assign count = cnt_q;
  assign out   = out_q;
endmodule

// File: rtl/tmr_readout.sv
module tmr_readout
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count,
  input  tmr_acc_e         acc,
  input  logic             cw_wr,
  input  logic             latch_cmd,
  input  logic             rd_act,
  input  logic             rd_done,
  output logic [BUS_W-1:0] dout,
  output logic             dout_oe
);
  logic [CNT_W-1:0] lat_q, lat_n, src;
  logic             held_q, held_n;
  logic             rptr_q, rptr_n;
  logic [BUS_W-1:0] sel_byte;

  assign src = held_q ? lat_q : count;

  always_comb begin
    case (acc)
      ACC_LO:  sel_byte = src[BUS_W-1:0];
      ACC_HI:  sel_byte = src[CNT_W-1:BUS_W];
      default: sel_byte = rptr_q ? src[CNT_W-1:BUS_W] : src[BUS_W-1:0];
    endcase
  end

  assign dout    = rd_act ? sel_byte : '0;
  assign dout_oe = rd_act;

  always_comb begin
    lat_n  = lat_q;
    held_n = held_q;
    rptr_n = rptr_q;
    if (cw_wr) begin
      held_n = 1'b0;
      rptr_n = 1'b0;
    end else begin
      if (latch_cmd && !held_q) begin
        held_n = 1'b1;
        lat_n  = count;
      end
      if (rd_done) begin
        if (acc == ACC_BOTH) begin
          rptr_n = ~rptr_q;
          if (rptr_q) held_n = 1'b0;
        end else begin
          held_n = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q  <= '0;
      held_q <= 1'b0;
      rptr_q <= 1'b0;
    end else begin
      lat_q  <= lat_n;
      held_q <= held_n;
      rptr_q <= rptr_n;
    end
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter logic [1:0] CHAN_ID     = 2'b00,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic [1:0] addr,
  input  logic [7:0] din,
  output logic [7:0] dout,
  output logic       dout_oe,
  input  logic       tick,
  input  logic       gate,
  output logic       out
);
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_s_n;
  logic                   wr_act, wr_q, wr_stb;
  logic                   rd_act, rd_q, rd_done;
  tmr_mode_e              mode_w;
  tmr_acc_e               acc_w;
  logic                   cw_wr_w, latch_w, load_w;
  logic [CNT_W-1:0]       load_val_w, count_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_s_n = rst_pipe[SYNC_STAGES-1];

  assign wr_act  = !cs_n && !wr_n;
  assign rd_act  = !cs_n && !rd_n && (addr == CHAN_ID);
  assign wr_stb  = wr_act && !wr_q;
  assign rd_done = rd_q && !rd_act;

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      wr_q <= 1'b0;
      rd_q <= 1'b0;
    end else begin
      wr_q <= wr_act;
      rd_q <= rd_act;
    end
  end

  tmr_ctrl #(.CHAN_ID(CHAN_ID)) u_ctrl (
    .clk(clk), .rst_n(rst_s_n), .wr_stb(wr_stb), .addr(addr), .din(din),
    .mode(mode_w), .acc(acc_w), .cw_wr(cw_wr_w), .latch_cmd(latch_w),
    .load_stb(load_w), .load_val(load_val_w)
  );

  tmr_counter u_counter (
    .clk(clk), .rst_n(rst_s_n), .mode(mode_w), .cw_wr(cw_wr_w),
    .load_stb(load_w), .load_val(load_val_w), .tick(tick), .gate(gate),
    .count(count_w), .out(out)
  );

  tmr_readout u_readout (
    .clk(clk), .rst_n(rst_s_n), .count(count_w), .acc(acc_w),
    .cw_wr(cw_wr_w), .latch_cmd(latch_w), .rd_act(rd_act),
    .rd_done(rd_done), .dout(dout), .dout_oe(dout_oe)
  );
endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cs_n,
  input logic        rd_n,
  input logic        tick,
  input logic        gate,
  input logic        out,
  input logic [7:0]  dout,
  input logic        dout_oe,
  input logic        cw_wr,
  input logic        mode_rate,
  input logic [15:0] count
);
  AST_CW_OUT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    cw_wr |=> out); // R4

  AST_RATE_LOW_ONE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_rate && !out && tick && gate) |=> out); // R5

  AST_OUT_MOVES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cw_wr) |=> $stable(out)); // R8

  AST_GATE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_rate && !gate && !cw_wr) |=> ($stable(count) && $stable(out))); // R7

  AST_DOUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || rd_n) |-> (dout == 8'h00 && !dout_oe)); // R10
endmodule

bind tmr_channel tmr_channel_chk u_chk (
  .clk(clk), .rst_n(rst_s_n), .cs_n(cs_n), .rd_n(rd_n), .tick(tick),
  .gate(gate), .out(out), .dout(dout), .dout_oe(dout_oe), .cw_wr(cw_wr_w),
  .mode_rate(mode_w), .count(count_w)
);

// File: tb/tmr_channel_test.sv
`timescale 1ns/1ps
module tmr_channel_test;
  logic       clk = 1'b0;
  logic       rst_n, cs_n, rd_n, wr_n, tick, gate, out, dout_oe;
  logic [1:0] addr;
  logic [7:0] din, dout, b;
  int         n_vec = 0, n_bad = 0;
  bit         done = 0;

  always #4 clk = ~clk;

  tmr_channel uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe),
    .tick(tick), .gate(gate), .out(out)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); cs_n = 0; addr = a; din = d; wr_n = 0;
    @(negedge clk); wr_n = 1; cs_n = 1;
  endtask

  task automatic bus_rd(output logic [7:0] d);
    @(negedge clk); cs_n = 0; addr = 2'd0; rd_n = 0;
    @(negedge clk); d = dout; rd_n = 1; cs_n = 1;
    @(negedge clk);
  endtask

  task automatic tk(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
    end
  endtask

  task automatic gate_pulse();
    @(negedge clk); gate = 0;
    @(negedge clk); gate = 1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 out after reset", out, 1);
    check("R10 dout_oe idle", dout_oe, 0);
    @(negedge clk); cs_n = 0; addr = 2'd0; rd_n = 0;
    @(negedge clk);
    check("R10 dout_oe during read", dout_oe, 1);
    check("R1 count low byte", dout, 8'h00);
    rd_n = 1; cs_n = 1;
    bus_rd(b); check("R1 count high byte", b, 8'h00);
  endtask

  task automatic t_rate();
    gate = 1;
    bus_wr(2'd3, 8'h34); bus_wr(2'd0, 8'h04); bus_wr(2'd0, 8'h00);
    check("R5 out before first tick", out, 1);
    for (int k = 0; k < 9; k++) begin
      tk(1); check($sformatf("R5 rate out tick %0d", k), out, (k % 4 == 3) ? 0 : 1);
    end
    bus_rd(b); check("R10 live low byte", b, 8'h04);
    bus_rd(b); check("R10 live high byte", b, 8'h00);
  endtask

  task automatic t_gate_hold();
    tk(1);
    @(negedge clk); gate = 0;
    tk(3);
    check("R7 out held with gate low", out, 1);
    bus_rd(b); check("R7 count held low byte", b, 8'h03);
    bus_rd(b);
    @(negedge clk); gate = 1;
    tk(2); check("R7 resumed, out low at 1", out, 0);
    tk(1); check("R7 resumed, reload out high", out, 1);
  endtask

  task automatic t_new_count();
    bus_wr(2'd0, 8'h06); bus_wr(2'd0, 8'h00);
    for (int i = 1; i <= 10; i++) begin
      tk(1); check($sformatf("R6 out tick %0d", i), out, (i == 3 || i == 9) ? 0 : 1);
    end
    bus_rd(b); check("R6 reload uses new count", b, 8'h06);
    bus_rd(b);
  endtask

  task automatic t_ignored_cw();
    bus_wr(2'd3, 8'h74);
    bus_wr(2'd3, 8'hF4);
    bus_wr(2'd3, 8'h30);
    check("R2 foreign bytes keep out", out, 1);
    tk(1);
    bus_rd(b); check("R2 still counting low byte", b, 8'h05);
    bus_rd(b); check("R2 still counting high byte", b, 8'h00);
    for (int j = 1; j <= 4; j++) begin
      tk(1); check($sformatf("R2 period kept tick %0d", j), out, (j == 4) ? 0 : 1);
    end
  endtask

  task automatic t_latch();
    bus_wr(2'd3, 8'h34);
    check("R4 out high after mode byte", out, 1);
    bus_wr(2'd0, 8'h34); bus_wr(2'd0, 8'h12);
    tk(2);
    bus_wr(2'd3, 8'h00);
    tk(2);
    bus_wr(2'd3, 8'h00);
    bus_rd(b); check("R11 latched low byte", b, 8'h33);
    tk(1);
    bus_rd(b); check("R11 latched high byte", b, 8'h12);
    bus_rd(b); check("R11 released low byte", b, 8'h30);
    bus_rd(b); check("R11 released high byte", b, 8'h12);
  endtask

  task automatic t_formats();
    bus_wr(2'd3, 8'h34); bus_wr(2'd0, 8'h99);
    bus_wr(2'd3, 8'h34); bus_wr(2'd0, 8'h05); bus_wr(2'd0, 8'h00);
    tk(1);
    bus_rd(b); check("R3 pointer reset low byte", b, 8'h05);
    bus_rd(b); check("R3 pointer reset high byte", b, 8'h00);
    bus_wr(2'd3, 8'h14); bus_wr(2'd0, 8'h07);
    tk(1);
    bus_rd(b); check("R3 low-only read", b, 8'h07);
    bus_rd(b); check("R10 low-only repeat read", b, 8'h07);
    bus_wr(2'd3, 8'h24); bus_wr(2'd0, 8'h02);
    tk(1);
    bus_rd(b); check("R3 high-only load", b, 8'h02);
    tk(1);
    bus_rd(b); check("R10 high-only after tick", b, 8'h01);
  endtask

  task automatic t_oneshot();
    @(negedge clk); gate = 0;
    bus_wr(2'd3, 8'h32); bus_wr(2'd0, 8'h03); bus_wr(2'd0, 8'h00);
    tk(2); check("R8 no trigger, out high", out, 1);
    @(negedge clk); gate = 1;
    for (int i = 1; i <= 4; i++) begin
      tk(1); check($sformatf("R8 pulse tick %0d", i), out, (i < 4) ? 0 : 1);
    end
    tk(2); check("R8 stays high after pulse", out, 1);
    bus_rd(b); check("R8 count ends at zero", b, 8'h00);
    bus_rd(b);
  endtask

  task automatic t_retrigger();
    gate_pulse();
    tk(1); check("R9 refire without rewrite", out, 0);
    tk(1);
    gate_pulse();
    for (int r = 1; r <= 4; r++) begin
      tk(1); check($sformatf("R9 extended tick %0d", r), out, (r < 4) ? 0 : 1);
    end
  endtask

  task automatic t_cw_stop();
    gate_pulse();
    tk(1); check("R4 pulse started", out, 0);
    bus_wr(2'd3, 8'h32);
    check("R4 mode byte forces out high", out, 1);
    gate_pulse();
    tk(2); check("R4 no count until reloaded", out, 1);
    bus_wr(2'd0, 8'h02); bus_wr(2'd0, 8'h00);
    gate_pulse();
    tk(1); check("R8 new count pulse tick 1", out, 0);
    tk(1); check("R8 new count pulse tick 2", out, 0);
    tk(1); check("R8 new count pulse end", out, 1);
  endtask

  initial begin
    rst_n = 0; cs_n = 1; rd_n = 1; wr_n = 1; addr = 0; din = 0; tick = 0; gate = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_rate();
    t_gate_hold();
    t_new_count();
    t_ignored_cw();
    t_latch();
    t_formats();
    t_oneshot();
    t_retrigger();
    t_cw_stop();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1;
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule